// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the purely combinational execution unit of a small load-store integer core. It takes two 32-bit source operands, a 5-bit shift count and a 4-bit operation code. In the same cycle it returns one 32-bit result and a flag that is high when that result is zero. The operations are add, subtract, three bitwise functions, signed and unsigned compare-to-flag, zero-filling shifts in both directions, and placement of a 16-bit constant in the upper half of the word.

The register stage around the unit supplies the operands, with immediates already extended. It also captures the result. A branch-on-equal sequence issues a subtract and uses the zero flag. An array bounds check issues the unsigned compare against the array length: a negative index appears as a very large unsigned value, so one compare also rejects it.

Top module: `alu_core`

## Requirements
- R1: With `opSel` = 0, `result` = `opA` + `opB`, wrapped modulo 2^32. No carry or overflow indication is produced.
- R2: With `opSel` = 1, `result` = `opA` - `opB`, wrapped modulo 2^32.
- R3: With `opSel` = 2, `result` is the bitwise AND of the operands. With `opSel` = 3, it is the bitwise OR.
- R4: With `opSel` = 4, `result` is the bitwise complement of (`opA` | `opB`).
- R5: With `opSel` = 5, `result` is 1 when `opA` < `opB` as two's-complement numbers, and 0 otherwise. Bits 31:1 are always zero.
- R6: With `opSel` = 6, `result` is 1 when `opA` < `opB` as unsigned numbers, and 0 otherwise.
- R7: With `opSel` = 7, `result` is `opB` shifted left by `shamt` positions (0 to 31). The vacated low bits are zero.
- R8: With `opSel` = 8, `result` is `opB` shifted right by `shamt` positions (0 to 31). The vacated high bits are zero.
- R9: With `opSel` = 9, `result` bits 31:16 equal `opB` bits 15:0, and `result` bits 15:0 are zero.
- R10: `zeroFlag` is 1 exactly when all 32 bits of `result` are zero, for every operation.
- R11: `opSel` values 10 to 15 give `result` = 0, so `zeroFlag` = 1, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First source operand |
| opB | input | 32 | Second source operand; the value that is shifted, and the source of the upper-half constant |
| shamt | input | 5 | Shift count for the two shift operations |
| opSel | input | 4 | Operation code (0 to 9 used, 10 to 15 give zero) |
| result | output | 32 | Result of the selected operation |
| zeroFlag | output | 1 | High when `result` is all zeros |

## Verification
Immediate assertions are evaluated whenever the inputs change. They cover the following properties:
- The shifter's vacated bit positions are zero in both directions.
- The compare results never carry anything above bit 0.
- The upper-half placement clears the low half.
- Unused codes drive a zero result at the ports.

The bench's scenarios are needed to show the rest:
- the arithmetic values themselves, including wraparound at the word boundary;
- the behaviour of the signed and unsigned compares around the sign boundary;
- the exact shifted values at counts 0 and 31;
- the zero flag after a subtract of equal operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_LUI  = 4'd9
  } aluOp_e;

  typedef enum logic [2:0] {
    RES_ARITH,
    RES_LOGIC,
    RES_LESS,
    RES_SHIFT,
    RES_UPPER,
    RES_NONE
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_NOR
  } logicSel_e;

  typedef struct packed {
    logic      subMode;
    logic      cmpSigned;
    logic      shiftLeft;
    logicSel_e logicSel;
    resSel_e   resSel;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobe_t      strobes
);

  always_comb begin
    strobes.subMode   = 1'b0;
    strobes.cmpSigned = 1'b0;
    strobes.shiftLeft = 1'b0;
    strobes.logicSel  = LG_AND;
    strobes.resSel    = RES_NONE;
    case (opSel)
      OP_ADD: strobes.resSel = RES_ARITH;
      OP_SUB: begin
        strobes.subMode = 1'b1;
        strobes.resSel  = RES_ARITH;
      end
      OP_AND: strobes.resSel = RES_LOGIC;
      OP_OR: begin
        strobes.logicSel = LG_OR;
        strobes.resSel   = RES_LOGIC;
      end
      OP_NOR: begin
        strobes.logicSel = LG_NOR;
        strobes.resSel   = RES_LOGIC;
      end
      OP_SLT: begin
        strobes.subMode   = 1'b1;
        strobes.cmpSigned = 1'b1;
        strobes.resSel    = RES_LESS;
      end
      OP_SLTU: begin
        strobes.subMode = 1'b1;
        strobes.resSel  = RES_LESS;
      end
      OP_SLL: begin
        strobes.shiftLeft = 1'b1;
        strobes.resSel    = RES_SHIFT;
      end
      OP_SRL: strobes.resSel = RES_SHIFT;
      OP_LUI: strobes.resSel = RES_UPPER;
      default: strobes.resSel = RES_NONE;
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               shiftLeft,
  output logic [DATA_W-1:0]  dataOut
);

  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] stage [0:SHAMT_W];

  // Left shifts reuse the right-shift stages on a bit-reversed word.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign revIn[b]  = dataIn[DATA_W-1-b];
    assign revOut[b] = stage[SHAMT_W][DATA_W-1-b];
  end

  assign stage[0] = shiftLeft ? revIn : dataIn;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    assign stage[s+1] = shamt[s] ? (stage[s] >> (2**s)) : stage[s];
  end

  assign dataOut = shiftLeft ? revOut : stage[SHAMT_W];

  // Vacated positions must be zero in both directions (R7, R8).
  always_comb begin
    if (!$isunknown({dataIn, shamt, shiftLeft})) begin
      if (shiftLeft) begin
        p_sll_fill_r7: assert ((dataOut & ~({DATA_W{1'b1}} << shamt)) == '0);
      end else begin
        p_srl_fill_r8: assert ((dataOut & ~({DATA_W{1'b1}} >> shamt)) == '0);
      end
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5,
  parameter int IMM_W   = 16
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shamt,
  input  aluStrobe_t         strobes,
  output logic [DATA_W-1:0]  result,
  output logic               zeroFlag
);

  localparam int MSB   = DATA_W - 1;
  localparam int LOW_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] bAdj;
  logic [DATA_W:0]   sumFull;
  logic              carryOut;
  logic              lessSigned;
  logic              lessUnsigned;
  logic              lessBit;
  logic [DATA_W-1:0] logicOut;
  logic [DATA_W-1:0] shiftOut;
  logic [DATA_W-1:0] upperOut;

  // One adder serves add, subtract and both compares.
  assign bAdj     = opB ^ {DATA_W{strobes.subMode}};
  assign sumFull  = {1'b0, opA} + {1'b0, bAdj} + {{DATA_W{1'b0}}, strobes.subMode};
  assign carryOut = sumFull[DATA_W];

  assign lessSigned   = (opA[MSB] ^ opB[MSB]) ? opA[MSB] : sumFull[MSB];
  assign lessUnsigned = ~carryOut;
  assign lessBit      = strobes.cmpSigned ? lessSigned : lessUnsigned;

  always_comb begin
    case (strobes.logicSel)
      LG_OR:   logicOut = opA | opB;
      LG_NOR:  logicOut = ~(opA | opB);
      default: logicOut = opA & opB;
    endcase
  end

  alu_shifter #(
    .DATA_W (DATA_W),
    .SHAMT_W(SHAMT_W)
  ) shifter_i (
    .dataIn   (opB),
    .shamt    (shamt),
    .shiftLeft(strobes.shiftLeft),
    .dataOut  (shiftOut)
  );

  assign upperOut = {opB[IMM_W-1:0], {LOW_W{1'b0}}};

  always_comb begin
    case (strobes.resSel)
      RES_ARITH: result = sumFull[DATA_W-1:0];
      RES_LOGIC: result = logicOut;
      RES_LESS:  result = {{(DATA_W-1){1'b0}}, lessBit};
      RES_SHIFT: result = shiftOut;
      RES_UPPER: result = upperOut;
      default:   result = '0;
    endcase
  end

  assign zeroFlag = (result == '0);

  always_comb begin
    if (!$isunknown({opA, opB, strobes})) begin
      if (strobes.resSel == RES_LESS) begin
        p_flag_width_r5: assert (result[DATA_W-1:1] == '0);
      end
      if (strobes.resSel == RES_UPPER) begin
        p_upper_low_clear_r9: assert (result[LOW_W-1:0] == '0);
      end
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5,
  parameter int IMM_W   = 16
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [OP_W-1:0]    opSel,
  output logic [DATA_W-1:0]  result,
  output logic               zeroFlag
);

  aluStrobe_t strobes;

  alu_ctrl ctrl_i (
    .opSel  (opSel),
    .strobes(strobes)
  );

  alu_datapath #(
    .DATA_W (DATA_W),
    .SHAMT_W(SHAMT_W),
    .IMM_W  (IMM_W)
  ) datapath_i (
    .opA     (opA),
    .opB     (opB),
    .shamt   (shamt),
    .strobes (strobes),
    .result  (result),
    .zeroFlag(zeroFlag)
  );

  // Unused codes must leave the result and flag in their zero state (R11).
  always_comb begin
    if (!$isunknown({opA, opB, shamt, opSel}) && (opSel > OP_W'(9))) begin
      p_unused_zero_r11: assert (result == '0 && zeroFlag);
    end
  end

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  shamt = '0;
  logic [3:0]  opSel = '0;
  logic [31:0] result;
  logic        zeroFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_core dut_i (
    .opA     (opA),
    .opB     (opB),
    .shamt   (shamt),
    .opSel   (opSel),
    .result  (result),
    .zeroFlag(zeroFlag)
  );

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return ~(a | b);
      4'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd6: return (a < b) ? 32'd1 : 32'd0;
      4'd7: return b << sh;
      4'd8: return b >> sh;
      4'd9: return {b[15:0], 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic applyCheck(input string tag, input logic [3:0] op, input logic [31:0] a,
                            input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] expRes;
    @(posedge clk);
    opSel = op;
    opA   = a;
    opB   = b;
    shamt = sh;
    expRes = model(op, a, b, sh);
    @(negedge clk);
    checks++;
    if (result !== expRes) begin
      failures++;
      $display("FAIL %s op=%0d result actual=%h expected=%h", tag, op, result, expRes);
    end
    checks++;
    if (zeroFlag !== (expRes == 32'd0)) begin
      failures++;
      $display("FAIL R10 op=%0d zeroFlag actual=%b expected=%b", op, zeroFlag, expRes == 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd20240);
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Reset state: all-zero inputs with add give zero result and flag set.
    applyCheck("R10", 4'd0, 32'd0, 32'd0, 5'd0);

    applyCheck("R1", 4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);
    applyCheck("R1", 4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
    applyCheck("R2", 4'd1, 32'd5, 32'd7, 5'd0);
    applyCheck("R2", 4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0);
    applyCheck("R3", 4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 5'd0);
    applyCheck("R3", 4'd3, 32'hF0F0_0000, 32'h0000_0F0F, 5'd0);
    applyCheck("R4", 4'd4, 32'd0, 32'd0, 5'd0);
    applyCheck("R4", 4'd4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0);
    applyCheck("R5", 4'd5, 32'hFFFF_FFFF, 32'd1, 5'd0);
    applyCheck("R5", 4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    applyCheck("R5", 4'd5, 32'd3, 32'd3, 5'd0);
    applyCheck("R6", 4'd6, 32'hFFFF_FFFF, 32'd1, 5'd0);
    applyCheck("R6", 4'd6, 32'd4, 32'd10, 5'd0);
    applyCheck("R7", 4'd7, 32'd0, 32'd1, 5'd31);
    applyCheck("R7", 4'd7, 32'd0, 32'hFFFF_FFFF, 5'd0);
    applyCheck("R7", 4'd7, 32'd0, 32'hFFFF_FFFF, 5'd13);
    applyCheck("R8", 4'd8, 32'd0, 32'h8000_0000, 5'd31);
    applyCheck("R8", 4'd8, 32'd0, 32'hFFFF_FFFF, 5'd7);
    applyCheck("R9", 4'd9, 32'hDEAD_BEEF, 32'h1234_ABCD, 5'd3);
    applyCheck("R11", 4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd9);
    applyCheck("R11", 4'd15, 32'h1, 32'h2, 5'd1);

    for (int i = 0; i < 800; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      applyCheck(tagOf(op), op, $urandom, $urandom, 5'($urandom));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule